// File: doc/BRIEF.md
# Serial Interrupt Line Peripheral Agent

This block lets a peripheral report a set of parallel interrupt requests to a host over a single shared interrupt line. The line is open-drain and active low, and the bus clock times every drive and every sample on it. The block never drives the line high. It either pulls the line low or leaves it released. The bench or the chip's pad logic combines that pull with the host and with any other agents on the line.

A serial interrupt cycle opens with a Start Frame. This is a low pulse that lasts between four and eight clocks. A train of three-clock request frames follows: first a sample slot, then recovery, then turn-around. The host closes the cycle with a short Stop Frame pulse. The width of that pulse chooses the start mode for the next cycle:

- In continuous mode, only the host opens a cycle.
- In quiet mode, the agent may pull the line low for exactly one clock when it has a request pending. The host then carries the start pulse on from there.

The agent takes a snapshot of its requests when each cycle begins. It keeps any request edge that arrives later and reports it in the following cycle.

Top module: `sirq_agent`

## Requirements
- R1: After reset the line is released, and the agent is in continuous mode. A pending request does not make it pull the line until a host-issued Start Frame has arrived.
- R2: The agent only ever pulls the line low. It pulls only during its own one-clock start pulse or during the sample slot of a requested frame. The line stays released in every recovery and turn-around clock.
- R3: A Start Frame is a run of consecutive low clocks whose count lies between 4 and 8 inclusive. A low run of 3 or fewer clocks, or of 9 or more, starts no frames. After such a run the agent returns to idle.
- R4: Frame 0's sample slot is the clock that follows the first high clock after a valid start pulse. Each frame lasts three clocks, in the order sample, recovery, turn-around. Frame n's sample slot comes 3n clocks after frame 0's. There are NUM_FRAMES frames in each cycle.
- R5: In the sample slot of frame n, the agent pulls the line low exactly when bit n of the cycle's request snapshot is set.
- R6: The snapshot is taken at the clock edge that validates the start pulse. It is the current request vector ORed with every rising request edge seen since the previous snapshot. A request that rises after the snapshot is therefore reported in the next cycle, even if it has fallen again by then.
- R7: In quiet mode, the agent pulls the line low for exactly one clock when the line is idle high and a request is pending (a request input is high, or a rising edge is held). It releases the line in the next clock.
- R8: In continuous mode, the agent never pulls the line outside sample slots.
- R9: After the last frame, the agent measures the host's low Stop pulse. A 2-clock pulse selects quiet mode and a 3-clock pulse selects continuous mode. Any other width leaves the mode unchanged. The agent then returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the line is driven and sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_FRAMES | Parallel interrupt requests, level sensitive; bit n maps to frame n |
| line_in | input | 1 | Sampled level of the shared serial interrupt line |
| line_pull | output | 1 | 1 pulls the line low; 0 releases it |

## Verification
The bench builds the agent with NUM_FRAMES = 5. This keeps each cycle short, so that a single run can cover these cases:
- every legal start width, plus widths 3 and 9;
- all three Stop widths;
- a quiet-mode self-start, with the host taking over the pulse;
- a request pulse injected partway through a cycle.

With five frames, the last frame index is not a power of two minus one. This exercises the wrap from the final turn-around slot into the Stop measurement.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int LOW_CNT_W = 4;

  localparam logic [LOW_CNT_W-1:0] START_MIN  = 4'd4;
  localparam logic [LOW_CNT_W-1:0] START_MAX  = 4'd8;
  localparam logic [LOW_CNT_W-1:0] STOP_QUIET = 4'd2;
  localparam logic [LOW_CNT_W-1:0] STOP_CONT  = 4'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KICK,
    ST_START,
    ST_FRAMES,
    ST_STOP
  } agent_st_t;

  typedef enum logic [1:0] {
    PH_SAMPLE,
    PH_RECOVER,
    PH_TURN
  } slot_ph_t;

endpackage

// File: rtl/sirq_low_meter.sv
module sirq_low_meter
  import sirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_in,
  output logic [LOW_CNT_W-1:0] low_w,
  output logic                 pulse_end
);
  localparam logic [LOW_CNT_W-1:0] CNT_MAX = '1;

  // Counts consecutive low samples, saturating at the counter maximum.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_w <= '0;
    end else if (line_in) begin
      low_w <= '0;
    end else if (low_w != CNT_MAX) begin
      low_w <= low_w + 1'b1;
    end
  end

  // The line is high now and a low run has just ended; low_w holds its length.
  assign pulse_end = line_in && (low_w != '0);
endmodule

// File: rtl/sirq_req_capture.sv
module sirq_req_capture #(
  parameter int NUM_FRAMES = 21
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FRAMES-1:0] irq_req,
  input  logic                  take,
  output logic [NUM_FRAMES-1:0] snap,
  output logic                  pending
);
  logic [NUM_FRAMES-1:0] prev_q;
  logic [NUM_FRAMES-1:0] held_q;
  logic [NUM_FRAMES-1:0] rise;

  assign rise    = irq_req & ~prev_q;
  assign pending = |(irq_req | held_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      held_q <= '0;
      snap   <= '0;
    end else begin
      prev_q <= irq_req;
      if (take) begin
        snap   <= irq_req | held_q;
        held_q <= '0;
      end else begin
        held_q <= held_q | rise;
      end
    end
  end
endmodule

// File: rtl/sirq_slot_seq.sv
module sirq_slot_seq
  import sirq_pkg::*;
#(
  parameter int NUM_FRAMES = 21,
  localparam int FW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  output slot_ph_t      ph,
  output logic [FW-1:0] fr,
  output logic          last
);
  localparam logic [FW-1:0] FR_LAST = FW'(NUM_FRAMES - 1);

  assign last = (ph == PH_TURN) && (fr == FR_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_SAMPLE;
      fr <= '0;
    end else if (load) begin
      ph <= PH_SAMPLE;
      fr <= '0;
    end else if (run) begin
      case (ph)
        PH_SAMPLE:  ph <= PH_RECOVER;
        PH_RECOVER: ph <= PH_TURN;
        default: begin
          ph <= PH_SAMPLE;
          fr <= last ? '0 : fr + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
  import sirq_pkg::*;
#(
  parameter int NUM_FRAMES = 21
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FRAMES-1:0] irq_req,
  input  logic                  line_in,
  output logic                  line_pull
);
  localparam int FW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;

  agent_st_t             st_q, st_d;
  logic                  quiet_q;
  logic [LOW_CNT_W-1:0]  low_w;
  logic                  pulse_end;
  logic [NUM_FRAMES-1:0] snap;
  logic                  pending;
  slot_ph_t              ph;
  logic [FW-1:0]         fr;
  logic                  last;
  logic                  start_ok;
  logic                  take;

  sirq_low_meter u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .low_w     (low_w),
    .pulse_end (pulse_end)
  );

  sirq_req_capture #(.NUM_FRAMES(NUM_FRAMES)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_req (irq_req),
    .take    (take),
    .snap    (snap),
    .pending (pending)
  );

  sirq_slot_seq #(.NUM_FRAMES(NUM_FRAMES)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (take),
    .run   (st_q == ST_FRAMES),
    .ph    (ph),
    .fr    (fr),
    .last  (last)
  );

  assign start_ok = (low_w >= START_MIN) && (low_w <= START_MAX);
  assign take     = (st_q == ST_START) && line_in && start_ok;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (!line_in)                 st_d = ST_START;
        else if (quiet_q && pending)  st_d = ST_KICK;
      end
      ST_KICK:   st_d = ST_START;
      ST_START:  if (line_in) st_d = start_ok ? ST_FRAMES : ST_IDLE;
      ST_FRAMES: if (last) st_d = ST_STOP;
      ST_STOP:   if (pulse_end) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      quiet_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_STOP && pulse_end) begin
        if (low_w == STOP_QUIET)     quiet_q <= 1'b1;
        else if (low_w == STOP_CONT) quiet_q <= 1'b0;
      end
    end
  end

  assign line_pull = (st_q == ST_KICK) ||
                     ((st_q == ST_FRAMES) && (ph == PH_SAMPLE) && snap[fr]);
endmodule

// File: rtl/sirq_agent_chk.sv
module sirq_agent_chk
  import sirq_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 line_in,
  input logic                 line_pull,
  input agent_st_t            st,
  input slot_ph_t             ph,
  input logic                 quiet,
  input logic [LOW_CNT_W-1:0] low_w
);
  AST_NO_SELF_START_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_KICK) |-> quiet); // R8

  AST_KICK_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_KICK) |=> !line_pull); // R7

  AST_PULL_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    line_pull |-> (st == ST_KICK || (st == ST_FRAMES && ph == PH_SAMPLE))); // R2

  AST_START_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_FRAMES) |-> $past(low_w >= START_MIN && low_w <= START_MAX)); // R3

  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FRAMES && ph == PH_SAMPLE) |=> (ph == PH_RECOVER)); // R4

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP && line_in && low_w == STOP_QUIET) |=> quiet); // R9
endmodule

bind sirq_agent sirq_agent_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_in   (line_in),
  .line_pull (line_pull),
  .st        (st_q),
  .ph        (ph),
  .quiet     (quiet_q),
  .low_w     (low_w)
);

// File: tb/sirq_agent_test.sv
module sirq_agent_test;
  localparam int NF = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NF-1:0] irq_req = '0;
  logic          host_low = 1'b0;
  logic          line_pull;
  logic          line_in;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  assign line_in = ~(host_low | line_pull);

  sirq_agent #(.NUM_FRAMES(NF)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .line_in   (line_in),
    .line_pull (line_pull)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One host-run cycle: the host drives the start pulse (or takes over a kick),
  // walks the frames recording sample-slot pulls, then issues a Stop pulse.
  task automatic host_cycle(input int start_w, input int stop_w, input bit kick,
                            input int inj_frame, input logic [NF-1:0] inj_mask,
                            output logic [NF-1:0] seen, output int slot_bad,
                            output bit kick_seen, output bit kick_held);
    int rest;
    int guard;
    seen = '0; slot_bad = 0; kick_seen = 0; kick_held = 0;
    rest = start_w;
    if (kick) begin
      guard = 0;
      do begin
        @(negedge clk);
        guard++;
      end while (!line_pull && guard < 40);
      kick_seen = line_pull;
      host_low = 1'b1;
      rest = start_w - 1;
      @(negedge clk);
      kick_held = line_pull;
      rest = rest - 1;
    end
    for (int i = 0; i < rest; i++) begin
      @(negedge clk);
      host_low = 1'b1;
    end
    @(negedge clk);
    host_low = 1'b0;
    for (int n = 0; n < NF; n++) begin
      @(negedge clk);
      seen[n] = line_pull;
      @(negedge clk);
      if (line_pull) slot_bad++;
      if (n == inj_frame) irq_req = irq_req | inj_mask;
      @(negedge clk);
      if (line_pull) slot_bad++;
      if (n == inj_frame) irq_req = irq_req & ~inj_mask;
    end
    for (int i = 0; i < stop_w; i++) begin
      @(negedge clk);
      host_low = 1'b1;
    end
    @(negedge clk);
    host_low = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic watch_quiet(input int n, input string req);
    int pulls = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (line_pull) pulls++;
    end
    chk(pulls == 0, req, pulls, 0);
  endtask

  // start width, stop width, request mask, expected sample-slot pulls
  typedef struct packed {
    logic [7:0]    start_w;
    logic [7:0]    stop_w;
    logic [NF-1:0] mask;
    logic [NF-1:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'd4, 8'd3, 5'b00010, 5'b00010},  // R3 R5 minimum width
    '{8'd8, 8'd3, 5'b10101, 5'b10101},  // R3 R4 maximum width
    '{8'd6, 8'd3, 5'b11111, 5'b11111},  // R5 every frame
    '{8'd5, 8'd3, 5'b00000, 5'b00000},  // R5 none
    '{8'd3, 8'd0, 5'b01100, 5'b00000},  // R3 too short
    '{8'd7, 8'd3, 5'b01100, 5'b01100},  // R6 held edge plus level
    '{8'd9, 8'd0, 5'b10001, 5'b00000},  // R3 too long
    '{8'd4, 8'd3, 5'b00000, 5'b10001}   // R6 edge kept after request fell
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [NF-1:0] seen;
    int  bad;
    bit  ks, kh;

    repeat (4) @(negedge clk);
    chk(line_pull == 1'b0, "R1 reset release", line_pull, 0);
    rst_n = 1'b1;

    // R1 R8: continuous after reset, request pending, no self start
    irq_req = 5'b00010;
    watch_quiet(15, "R1 no start before host");

    foreach (VECS[i]) begin
      irq_req = VECS[i].mask;
      host_cycle(int'(VECS[i].start_w), int'(VECS[i].stop_w), 0, -1, '0,
                 seen, bad, ks, kh);
      chk(seen == VECS[i].exp, "R5 frame pulls", seen, VECS[i].exp);
      chk(bad == 0, "R2 recovery/turn released", bad, 0);
    end

    // R6: request pulse after frame 0's sample slot waits for next cycle
    irq_req = '0;
    host_cycle(4, 3, 0, 2, 5'b00001, seen, bad, ks, kh);
    chk(seen == 5'b00000, "R6 mid-cycle not in current", seen, 0);
    host_cycle(4, 3, 0, -1, '0, seen, bad, ks, kh);
    chk(seen == 5'b00001, "R6 mid-cycle in next", seen, 1);

    // R9: stop width 2 selects quiet mode; no kick without a request
    host_cycle(5, 2, 0, -1, '0, seen, bad, ks, kh);
    watch_quiet(10, "R7 no kick when nothing pending");

    // R7: quiet self-start, one clock, host takes over
    irq_req = 5'b00100;
    host_cycle(5, 3, 1, -1, '0, seen, bad, ks, kh);
    chk(ks == 1'b1, "R7 kick issued", ks, 1);
    chk(kh == 1'b0, "R7 kick lasts one clock", kh, 0);
    chk(seen == 5'b00100, "R7 R5 kicked cycle frames", seen, 5'b00100);

    // R8 R9: stop width 3 back to continuous; request held high, no start
    watch_quiet(15, "R8 continuous no self start");

    // R9: stop width 4 leaves mode unchanged (still continuous)
    host_cycle(4, 4, 0, -1, '0, seen, bad, ks, kh);
    chk(seen == 5'b00100, "R5 level request again", seen, 5'b00100);
    watch_quiet(15, "R9 odd stop width keeps mode");

    // R9: width 2 again, level request kicks right away
    host_cycle(4, 2, 0, -1, '0, seen, bad, ks, kh);
    host_cycle(4, 3, 1, -1, '0, seen, bad, ks, kh);
    chk(ks == 1'b1, "R9 quiet after width 2", ks, 1);
    chk(seen == 5'b00100, "R4 frames after kick", seen, 5'b00100);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule